// File: doc/BRIEF.md
# Octal DAC Serial Command Decoder

This block is the digital front end of a multi-channel digital-to-analog converter. A host drives a four-wire serial link in SPI mode 0. While the active-low select is held low, bits are taken MSB first on each rising serial clock. When the select returns high after exactly 32 bits, the collected word is decoded as one command. The serial pins are oversampled by the system clock through synchronizer chains, so the link is asynchronous to that clock.

Each channel holds a staging (input) code and an active (output) code. Commands can stage a code, promote staged codes to the output, or do both. A per-channel hold mask can block promotion by the shared-update commands. Further commands set per-channel power-down modes, zero all codes, return everything to the power-on state, or set two configuration flags. The channel count and the code resolution (12, 14 or 16 bits) are parameters.

Top module: `dac_cmd_decoder`

## Requirements
- R1: A command is taken only when the select rises after exactly 32 rising serial-clock edges, with bits taken MSB first. Word bits 27:24 carry the command and bits 23:20 carry the channel address. Bits 31:28 are ignored.
- R2: A word that ends after any bit count other than 32, shorter or longer, changes no state.
- R3: The data code is taken from bits 19 down to 20−RES_BITS of the word. Output channel i appears on `dac_code[i*RES_BITS +: RES_BITS]`.
- R4: Command 0 writes the staging code of the addressed channel and leaves its active code unchanged. Command 1 copies the staging code to the active code.
- R5: Command 3 writes both the staging and active codes of the addressed channel, whatever the hold mask holds.
- R6: Command 2 writes the staging code of the addressed channel, then promotes the staging code of every channel whose hold bit is clear. The channel just written promotes its new value.
- R7: Address 15 selects every channel. For commands 0 to 3, any other address at or above NUM_CH makes the whole command do nothing.
- R8: Command 4 sets the power-down mode of every channel whose bit is set in word bits 7:0, using the mode in bits 9:8. The modes are 0 normal, 1 one-kilohm pull-down, 2 hundred-kilohm pull-down and 3 high impedance. Channel i's mode appears on `pd_mode[2*i+1:2*i]`.
- R9: Command 6 loads the hold mask from word bits 7:0. A set bit blocks promotion by commands 1 and 2 for that channel.
- R10: Command 5 zeroes every staging code and every active code.
- R11: Command 7 zeroes all codes, power-down modes, the hold mask and both configuration flags.
- R12: Command 8 sets `int_ref_en` from word bit 0 and `daisy_en` from word bit 1.
- R13: After reset all outputs are zero. Commands 9 to 15 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock, mode 0 |
| mosi | input | 1 | Serial data in |
| cs_n | input | 1 | Active-low frame select |
| dac_code | output | NUM_CH*RES_BITS | Active codes, channel 0 in the low bits |
| pd_mode | output | 2*NUM_CH | Power-down mode per channel |
| int_ref_en | output | 1 | Internal reference enable flag |
| daisy_en | output | 1 | Chained-mode enable flag |

## Verification
The assertions assume the serial pins are slow relative to the system clock. Each serial-clock level and each select level is held for more clock cycles than the synchronizer depth plus one. The data line is steady around every rising serial-clock edge, and the select never moves in the same cycle as a serial-clock edge. The stimulus holds each half-period for four system clocks, changes data only while the serial clock is low, and leaves idle time around every select transition. Short and long frames and out-of-range addresses come from weighted random draws and directed cases.

// File: rtl/dacdec_pkg.sv
package dacdec_pkg;
  localparam int FRAME_W  = 32;
  localparam int KEEP_W   = 28;
  localparam logic [3:0] ADDR_ALL = 4'hF;

  typedef enum logic [3:0] {
    CMD_WR_IN      = 4'd0,
    CMD_UPD        = 4'd1,
    CMD_WR_UPD_ALL = 4'd2,
    CMD_WR_UPD_ONE = 4'd3,
    CMD_PWRDN      = 4'd4,
    CMD_CLEAR      = 4'd5,
    CMD_HOLD       = 4'd6,
    CMD_RESET      = 4'd7,
    CMD_CONFIG     = 4'd8
  } cmd_e;

  // address legal for a channel count
  function automatic logic addr_ok(logic [3:0] addr, int nch);
    return (addr == ADDR_ALL) || (int'(addr) < nch);
  endfunction

  // does address select channel idx
  function automatic logic chan_hit(logic [3:0] addr, int idx);
    return (addr == ADDR_ALL) || (addr == 4'(idx));
  endfunction
endpackage

// File: rtl/dacdec_spi_rx.sv
module dacdec_spi_rx #(
  parameter int FRAME_W     = 32,
  parameter int KEEP_W      = 28,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              mosi,
  input  logic              cs_n,
  output logic              frame_ok,
  output logic [KEEP_W-1:0] frame
);
  localparam int CNT_W   = $clog2(FRAME_W + 2);
  localparam int CNT_SAT = FRAME_W + 1;
  localparam int TOP     = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sclk_s, mosi_s, cs_s;
  logic                   sclk_q, cs_q;
  logic [CNT_W-1:0]       bit_cnt;
  logic [KEEP_W-1:0]      shreg;
  logic                   sclk_rise, cs_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_s <= '0;
      mosi_s <= '0;
      cs_s   <= '1;
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
    end else begin
      sclk_s <= {sclk_s[SYNC_STAGES-2:0], sclk};
      mosi_s <= {mosi_s[SYNC_STAGES-2:0], mosi};
      cs_s   <= {cs_s[SYNC_STAGES-2:0], cs_n};
      sclk_q <= sclk_s[TOP];
      cs_q   <= cs_s[TOP];
    end
  end

  assign sclk_rise = sclk_s[TOP] & ~sclk_q;
  assign cs_rise   = cs_s[TOP] & ~cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      shreg   <= '0;
    end else if (cs_s[TOP]) begin
      bit_cnt <= '0;
    end else if (sclk_rise) begin
      shreg <= {shreg[KEEP_W-2:0], mosi_s[TOP]};
      if (bit_cnt != CNT_W'(CNT_SAT)) bit_cnt <= bit_cnt + 1'b1;
    end
  end

  assign frame_ok = cs_rise && (bit_cnt == CNT_W'(FRAME_W));
  assign frame    = shreg;
endmodule

// File: rtl/dacdec_decode.sv
module dacdec_decode
  import dacdec_pkg::*;
#(
  parameter int NUM_CH   = 8,
  parameter int RES_BITS = 16
) (
  input  logic                frame_ok,
  input  logic [KEEP_W-1:0]   frame,
  output logic [NUM_CH-1:0]   wr_in,
  output logic [NUM_CH-1:0]   upd_req,
  output logic [NUM_CH-1:0]   upd_force,
  output logic [NUM_CH-1:0]   pd_we,
  output logic [RES_BITS-1:0] code,
  output logic [1:0]          pd_val,
  output logic [NUM_CH-1:0]   hold_val,
  output logic [1:0]          cfg_val,
  output logic                clr,
  output logic                rst_cmd,
  output logic                hold_we,
  output logic                cfg_we
);
  logic [3:0] cmd, addr;
  logic       ok;

  assign cmd      = frame[27:24];
  assign addr     = frame[23:20];
  assign ok       = addr_ok(addr, NUM_CH);
  assign code     = frame[19 -: RES_BITS];
  assign pd_val   = frame[9:8];
  assign hold_val = frame[NUM_CH-1:0];
  assign cfg_val  = frame[1:0];

  always_comb begin
    wr_in     = '0;
    upd_req   = '0;
    upd_force = '0;
    pd_we     = '0;
    clr       = 1'b0;
    rst_cmd   = 1'b0;
    hold_we   = 1'b0;
    cfg_we    = 1'b0;
    if (frame_ok) begin
      case (cmd)
        CMD_WR_IN:
          for (int i = 0; i < NUM_CH; i++) wr_in[i] = ok && chan_hit(addr, i);
        CMD_UPD:
          for (int i = 0; i < NUM_CH; i++) upd_req[i] = ok && chan_hit(addr, i);
        CMD_WR_UPD_ALL:
          for (int i = 0; i < NUM_CH; i++) begin
            wr_in[i]   = ok && chan_hit(addr, i);
            upd_req[i] = ok;
          end
        CMD_WR_UPD_ONE:
          for (int i = 0; i < NUM_CH; i++) begin
            wr_in[i]     = ok && chan_hit(addr, i);
            upd_force[i] = ok && chan_hit(addr, i);
          end
        CMD_PWRDN:  pd_we   = frame[NUM_CH-1:0];
        CMD_CLEAR:  clr     = 1'b1;
        CMD_HOLD:   hold_we = 1'b1;
        CMD_RESET:  rst_cmd = 1'b1;
        CMD_CONFIG: cfg_we  = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dacdec_regfile.sv
module dacdec_regfile #(
  parameter int NUM_CH   = 8,
  parameter int RES_BITS = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_CH-1:0]          wr_in,
  input  logic [NUM_CH-1:0]          upd_req,
  input  logic [NUM_CH-1:0]          upd_force,
  input  logic [NUM_CH-1:0]          pd_we,
  input  logic [RES_BITS-1:0]        code,
  input  logic [1:0]                 pd_val,
  input  logic [NUM_CH-1:0]          hold_val,
  input  logic [1:0]                 cfg_val,
  input  logic                       clr,
  input  logic                       rst_cmd,
  input  logic                       hold_we,
  input  logic                       cfg_we,
  output logic [NUM_CH*RES_BITS-1:0] dac_code,
  output logic [2*NUM_CH-1:0]        pd_mode,
  output logic [1:0]                 cfg_q
);
  logic [NUM_CH-1:0] hold_q;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic [RES_BITS-1:0] in_q, act_q;
    logic [1:0]          pd_q;
    logic                promote;

    assign promote = upd_force[i] | (upd_req[i] & ~hold_q[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        in_q  <= '0;
        act_q <= '0;
      end else if (rst_cmd || clr) begin
        in_q  <= '0;
        act_q <= '0;
      end else begin
        if (wr_in[i]) in_q <= code;
        if (promote)  act_q <= wr_in[i] ? code : in_q;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        pd_q <= 2'd0;
      else if (rst_cmd)  pd_q <= 2'd0;
      else if (pd_we[i]) pd_q <= pd_val;
    end

    assign dac_code[i*RES_BITS +: RES_BITS] = act_q;
    assign pd_mode[2*i +: 2]                = pd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      cfg_q  <= '0;
    end else if (rst_cmd) begin
      hold_q <= '0;
      cfg_q  <= '0;
    end else begin
      if (hold_we) hold_q <= hold_val;
      if (cfg_we)  cfg_q  <= cfg_val;
    end
  end
endmodule

// File: rtl/dac_cmd_decoder.sv
module dac_cmd_decoder
  import dacdec_pkg::*;
#(
  parameter int NUM_CH      = 8,
  parameter int RES_BITS    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sclk,
  input  logic                       mosi,
  input  logic                       cs_n,
  output logic [NUM_CH*RES_BITS-1:0] dac_code,
  output logic [2*NUM_CH-1:0]        pd_mode,
  output logic                       int_ref_en,
  output logic                       daisy_en
);
  // named internal events for the checker
  logic                frame_ok;
  logic [KEEP_W-1:0]   frame;
  logic                clr_evt, rst_evt, cfg_evt, hold_evt;
  logic [NUM_CH-1:0]   wr_in, upd_req, upd_force, pd_we, hold_val;
  logic [RES_BITS-1:0] code;
  logic [1:0]          pd_val, cfg_val, cfg_q;

  dacdec_spi_rx #(
    .FRAME_W(FRAME_W), .KEEP_W(KEEP_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_rx (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .mosi(mosi), .cs_n(cs_n),
    .frame_ok(frame_ok), .frame(frame)
  );

  dacdec_decode #(.NUM_CH(NUM_CH), .RES_BITS(RES_BITS)) u_dec (
    .frame_ok(frame_ok), .frame(frame),
    .wr_in(wr_in), .upd_req(upd_req), .upd_force(upd_force), .pd_we(pd_we),
    .code(code), .pd_val(pd_val), .hold_val(hold_val), .cfg_val(cfg_val),
    .clr(clr_evt), .rst_cmd(rst_evt), .hold_we(hold_evt), .cfg_we(cfg_evt)
  );

  dacdec_regfile #(.NUM_CH(NUM_CH), .RES_BITS(RES_BITS)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_in(wr_in), .upd_req(upd_req), .upd_force(upd_force), .pd_we(pd_we),
    .code(code), .pd_val(pd_val), .hold_val(hold_val), .cfg_val(cfg_val),
    .clr(clr_evt), .rst_cmd(rst_evt), .hold_we(hold_evt), .cfg_we(cfg_evt),
    .dac_code(dac_code), .pd_mode(pd_mode), .cfg_q(cfg_q)
  );

  assign int_ref_en = cfg_q[0];
  assign daisy_en   = cfg_q[1];
endmodule

// File: rtl/dacdec_chk.sv
module dacdec_chk #(
  parameter int NUM_CH   = 8,
  parameter int RES_BITS = 16,
  parameter int KEEP_W   = 28
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       frame_ok,
  input logic [KEEP_W-1:0]          frame,
  input logic                       clr_evt,
  input logic                       rst_evt,
  input logic                       cfg_evt,
  input logic [NUM_CH*RES_BITS-1:0] dac_code,
  input logic [2*NUM_CH-1:0]        pd_mode,
  input logic                       int_ref_en,
  input logic                       daisy_en
);
  // R1
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok |=> !frame_ok);

  // R2
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_ok |=> ($stable(dac_code) && $stable(pd_mode)
                   && $stable(int_ref_en) && $stable(daisy_en)));

  // R10
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_evt |=> (dac_code == '0));

  // R11
  reset_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_evt |=> (dac_code == '0 && pd_mode == '0 && !int_ref_en && !daisy_en));

  // R12
  config_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_evt |=> (int_ref_en == $past(frame[0]) && daisy_en == $past(frame[1])));

  // R13
  event_needs_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_evt || rst_evt || cfg_evt) |-> frame_ok);
endmodule

bind dac_cmd_decoder dacdec_chk #(
  .NUM_CH(NUM_CH), .RES_BITS(RES_BITS), .KEEP_W(dacdec_pkg::KEEP_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_ok(frame_ok), .frame(frame),
  .clr_evt(clr_evt), .rst_evt(rst_evt), .cfg_evt(cfg_evt),
  .dac_code(dac_code), .pd_mode(pd_mode),
  .int_ref_en(int_ref_en), .daisy_en(daisy_en)
);

// File: tb/dac_cmd_decoder_test.sv
`timescale 1ns/1ps
module dac_cmd_decoder_test;
  localparam int NCH = 8;
  localparam int RES = 16;

  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, mosi = 1'b0, cs_n = 1'b1;
  logic [NCH*RES-1:0] dac_code;
  logic [2*NCH-1:0]   pd_mode;
  logic               int_ref_en, daisy_en;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [RES-1:0] m_in  [NCH];
  logic [RES-1:0] m_act [NCH];
  logic [1:0]     m_pd  [NCH];
  logic [NCH-1:0] m_hold;
  logic [1:0]     m_cfg;

  always #10 clk = ~clk;

  dac_cmd_decoder #(.NUM_CH(NCH), .RES_BITS(RES)) uut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .mosi(mosi), .cs_n(cs_n),
    .dac_code(dac_code), .pd_mode(pd_mode),
    .int_ref_en(int_ref_en), .daisy_en(daisy_en)
  );

  function automatic logic [31:0] mk(int cmd, int addr, int data);
    return (32'(cmd) << 24) | (32'(addr & 15) << 20) | 32'(data);
  endfunction

  function automatic logic [31:0] mk_code(int cmd, int addr, logic [RES-1:0] c);
    return mk(cmd, addr, 0) | (32'(c) << (20 - RES));
  endfunction

  function automatic void model_reset();
    for (int i = 0; i < NCH; i++) begin
      m_in[i] = '0; m_act[i] = '0; m_pd[i] = 2'd0;
    end
    m_hold = '0;
    m_cfg  = 2'd0;
  endfunction

  function automatic void model(logic [31:0] f);
    int cmd = int'(f[27:24]);
    int a   = int'(f[23:20]);
    logic [RES-1:0] c = f[19 -: RES];
    bit legal = (a == 15) || (a < NCH);
    case (cmd)
      0: if (legal) for (int i = 0; i < NCH; i++) if (a == 15 || a == i) m_in[i] = c;
      1: if (legal) for (int i = 0; i < NCH; i++)
           if ((a == 15 || a == i) && !m_hold[i]) m_act[i] = m_in[i];
      2: if (legal) begin
           for (int i = 0; i < NCH; i++) if (a == 15 || a == i) m_in[i] = c;
           for (int i = 0; i < NCH; i++) if (!m_hold[i]) m_act[i] = m_in[i];
         end
      3: if (legal) for (int i = 0; i < NCH; i++)
           if (a == 15 || a == i) begin m_in[i] = c; m_act[i] = c; end
      4: for (int i = 0; i < NCH; i++) if (f[i]) m_pd[i] = f[9:8];
      5: for (int i = 0; i < NCH; i++) begin m_in[i] = '0; m_act[i] = '0; end
      6: m_hold = f[NCH-1:0];
      7: model_reset();
      8: m_cfg = f[1:0];
      default: ;
    endcase
  endfunction

  task automatic check_all(string tag);
    logic [NCH*RES-1:0] e_code;
    logic [2*NCH-1:0]   e_pd;
    for (int i = 0; i < NCH; i++) begin
      e_code[i*RES +: RES] = m_act[i];
      e_pd[2*i +: 2]       = m_pd[i];
    end
    checks++;
    if (dac_code !== e_code || pd_mode !== e_pd || {daisy_en, int_ref_en} !== m_cfg) begin
      errors++;
      $display("FAIL %s: actual code=%h pd=%h cfg=%b expected code=%h pd=%h cfg=%b",
               tag, dac_code, pd_mode, {daisy_en, int_ref_en}, e_code, e_pd, m_cfg);
    end
  endtask

  task automatic wclk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(logic [31:0] f, int nbits, string tag);
    cs_n = 1'b0;
    wclk(4);
    for (int b = 0; b < nbits; b++) begin
      mosi = (b < 32) ? f[31-b] : 1'b0;
      sclk = 1'b0; wclk(4);
      sclk = 1'b1; wclk(4);
    end
    sclk = 1'b0; wclk(4);
    cs_n = 1'b1;
    wclk(12);
    if (nbits == 32) model(f);
    check_all(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    wclk(5);
    check_all("R13 reset state");
    rst_n = 1'b1;
    wclk(4);

    send(mk_code(3, 2, 16'h1234), 32, "R5 R3 write+update ch2");
    send(mk_code(0, 5, 16'hABCD), 32, "R4 write staging only");
    send(mk(1, 5, 0), 32, "R4 promote ch5");
    send(mk(6, 0, 32'h20), 32, "R9 load hold mask");
    send(mk_code(0, 5, 16'h5555), 32, "R4 stage ch5 under hold");
    send(mk(1, 5, 0), 32, "R9 promote blocked");
    send(mk_code(3, 5, 16'h7777), 32, "R5 forced update ignores hold");
    send(mk_code(0, 0, 16'h0F0F), 32, "R4 stage ch0");
    send(mk_code(0, 5, 16'h9999), 32, "R4 stage ch5");
    send(mk_code(2, 1, 16'h1111), 32, "R6 write ch1 update unheld");
    send(mk_code(0, 15, 16'h4242), 32, "R7 broadcast stage");
    send(mk(6, 0, 0), 32, "R9 clear hold");
    send(mk(1, 15, 0), 32, "R7 broadcast promote");
    send(mk_code(3, 9, 16'hDEAD), 32, "R7 out of range address");
    send(mk_code(3, 0, 16'hBEEF), 31, "R2 short frame");
    send(mk_code(3, 0, 16'hBEEF), 33, "R2 long frame");
    send(32'hF000_0000 | mk_code(3, 3, 16'hC3C3), 32, "R1 top bits ignored");
    send(mk(4, 0, 32'h20C), 32, "R8 power-down mode 2");
    send(mk(4, 0, 32'h381), 32, "R8 power-down mode 3");
    send(mk(8, 0, 3), 32, "R12 config both");
    send(mk(8, 0, 1), 32, "R12 config ref only");
    send(mk_code(10, 1, 16'h6666), 32, "R13 unused command");
    send(mk(5, 0, 0), 32, "R10 clear");
    send(mk_code(3, 4, 16'h0101), 32, "R5 after clear");
    send(mk(7, 0, 0), 32, "R11 reset command");

    for (int n = 0; n < 250; n++) begin
      int cmd   = ($urandom % 4 == 0) ? int'($urandom % 16) : int'($urandom % 9);
      int addr  = int'($urandom % 16);
      int nbits = ($urandom % 16 == 0) ? (($urandom % 2 == 0) ? 20 : 33) : 32;
      logic [31:0] f = mk(cmd, addr, int'($urandom & 32'h000F_FFFF));
      if (cmd == 7 && ($urandom % 3 != 0)) f[27:24] = 4'd3;
      send(f, nbits, "R1 random frame");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule